// File: doc/BRIEF.md
# Sectored Pair-Mapping Translation Buffer

This block is a fully associative address translation buffer in which every tag stands for an aligned pair of neighbouring virtual pages. Each tag holds two physical page numbers, one for the even page of the pair and one for the odd page. Each of the two has its own valid bit. With the default of 64 tags the array holds up to 128 page mappings while the comparator count stays at 64, which keeps the associative search short enough for one cycle.

A lookup presents a virtual page number. All bits except bit 0 are compared against every stored tag at once, and bit 0 chooses the half whose translation is returned. The result is purely combinational.

A fill presents a virtual page number and its physical page number, and takes effect at the next clock edge. If the pair's tag is already resident, only the addressed half is written. Otherwise a new entry is claimed in round-robin order, and the other half of that entry starts out invalid. Page-table walking and mixed page sizes belong to other blocks.

Top module: `tlb_sect`

## Requirements
- R1: While `rst` is high at a clock edge, every entry is cleared, so each lookup in the following cycle reports a miss.
- R2: The tag is virtual page number bits [VPN_W-1:1]. Bit 0 selects the half: 0 selects the even slot and 1 selects the odd slot.
- R3: `lk_hit` is 1 only when a resident tag matches and the selected half is valid. A tag match on an invalid half is a miss.
- R4: On a miss, `lk_ppn` is all zeros. On a hit, it carries the stored physical page number of the selected half.
- R5: A lookup is answered in the same cycle from the contents held before the current clock edge. A fill becomes visible to lookups from the cycle after its edge, and a lookup made in the fill's own cycle sees the old contents.
- R6: A fill whose tag is already resident writes only the addressed half. The partner half keeps its number and its valid bit, and no new entry is claimed.
- R7: A fill with a tag that is not resident claims the entry named by a round-robin pointer. The pointer is 0 after reset, moves up by one for each such fill, and wraps from NUM_TAGS-1 to 0. The claimed entry drops both of its previous mappings, and its partner half becomes invalid.
- R8: A fill to a half that is already valid replaces the stored physical page number with the new one.
- R9: NUM_TAGS distinct pairs with both halves filled give 2*NUM_TAGS mappings that are all resident and correct at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Translation found and valid |
| lk_ppn | output | PPN_W | Translated physical page number, zero on a miss |
| fl_en | input | 1 | Fill request for this cycle |
| fl_vpn | input | VPN_W | Virtual page number being filled |
| fl_ppn | input | PPN_W | Physical page number being filled |

## Verification
A lookup and a fill can occur in the same cycle. In that case the lookup must return the contents held before the fill, including the case where the fill is about to evict the very entry being read. The bench sets up both cases: a lookup of the page being filled in the fill's own cycle, and a lookup of a victim pair while the wrapping round-robin fill claims its entry. The output is compared against a behavioural model that applies each fill only after the edge, and the same lookup is repeated one cycle later to confirm the new contents.

// File: rtl/tlb_sect_pkg.sv
package tlb_sect_pkg;

    localparam int unsigned DEF_VPN_W = 20;
    localparam int unsigned DEF_PPN_W = 16;
    localparam int unsigned DEF_TAGS  = 64;

    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_e;

    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_MERGE = 2'd1,
        FILL_ALLOC = 2'd2
    } fill_kind_e;

    function automatic slot_e slot_of(input logic b0);
        return slot_e'(b0);
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tlb_sect_entry.sv
module tlb_sect_entry
    import tlb_sect_pkg::*;
#(
    parameter int unsigned VPN_W = DEF_VPN_W,
    parameter int unsigned PPN_W = DEF_PPN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic             wr_en,
    input  fill_kind_e       wr_kind,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             fl_tag_hit
);

    localparam int unsigned TAG_W = VPN_W - 1;

    typedef struct packed {
        logic                  tag_vld;
        logic [TAG_W-1:0]      tag;
        logic [1:0]            slot_vld;
        logic [1:0][PPN_W-1:0] ppn;
    } ent_t;

    ent_t  ent_q;
    slot_e lk_sel;
    slot_e fl_sel;
    logic  lk_tag_eq;

    assign lk_sel     = slot_of(lk_vpn[0]);
    assign fl_sel     = slot_of(fl_vpn[0]);
    assign lk_tag_eq  = ent_q.tag_vld && (ent_q.tag == lk_vpn[VPN_W-1:1]);
    assign fl_tag_hit = ent_q.tag_vld && (ent_q.tag == fl_vpn[VPN_W-1:1]);

    always_comb begin
        lk_hit = lk_tag_eq && ent_q.slot_vld[lk_sel];
        lk_ppn = lk_hit ? ent_q.ppn[lk_sel] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                FILL_ALLOC: begin
                    ent_q.tag_vld          <= 1'b1;
                    ent_q.tag              <= fl_vpn[VPN_W-1:1];
                    ent_q.slot_vld[fl_sel]  <= 1'b1;
                    ent_q.slot_vld[~fl_sel] <= 1'b0;
                    ent_q.ppn[fl_sel]       <= fl_ppn;
                end
                FILL_MERGE: begin
                    ent_q.slot_vld[fl_sel] <= 1'b1;
                    ent_q.ppn[fl_sel]      <= fl_ppn;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tlb_sect_rr.sv
module tlb_sect_rr
    import tlb_sect_pkg::*;
#(
    parameter int unsigned NUM_TAGS = DEF_TAGS,
    localparam int unsigned IDX_W   = idx_width(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TAGS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_sect_merge.sv
module tlb_sect_merge
    import tlb_sect_pkg::*;
#(
    parameter int unsigned NUM_TAGS = DEF_TAGS,
    parameter int unsigned PPN_W    = DEF_PPN_W
) (
    input  logic [NUM_TAGS-1:0]            hit_vec,
    input  logic [NUM_TAGS-1:0][PPN_W-1:0] ppn_vec,
    output logic                           hit,
    output logic [PPN_W-1:0]               ppn
);

    always_comb begin
        hit = 1'b0;
        ppn = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            hit = hit | hit_vec[i];
            ppn = ppn | ppn_vec[i];
        end
    end

endmodule

// File: rtl/tlb_sect.sv
module tlb_sect
    import tlb_sect_pkg::*;
#(
    parameter int unsigned VPN_W    = DEF_VPN_W,
    parameter int unsigned PPN_W    = DEF_PPN_W,
    parameter int unsigned NUM_TAGS = DEF_TAGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn
);

    localparam int unsigned IDX_W = idx_width(NUM_TAGS);

    logic [NUM_TAGS-1:0]            ent_lk_hit;
    logic [NUM_TAGS-1:0][PPN_W-1:0] ent_lk_ppn;
    logic [NUM_TAGS-1:0]            ent_fl_hit;
    logic [NUM_TAGS-1:0]            ent_wr;
    logic                           any_fl_hit;
    logic [IDX_W-1:0]               rr_ptr;
    fill_kind_e                     fill_kind;

    assign any_fl_hit = |ent_fl_hit;

    always_comb begin
        if (!fl_en)          fill_kind = FILL_IDLE;
        else if (any_fl_hit) fill_kind = FILL_MERGE;
        else                 fill_kind = FILL_ALLOC;
    end

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ent
        assign ent_wr[g] = fl_en &&
            (any_fl_hit ? ent_fl_hit[g] : (rr_ptr == IDX_W'(g)));

        tlb_sect_entry #(
            .VPN_W (VPN_W),
            .PPN_W (PPN_W)
        ) ent_i (
            .clk        (clk),
            .rst        (rst),
            .lk_vpn     (lk_vpn),
            .fl_vpn     (fl_vpn),
            .fl_ppn     (fl_ppn),
            .wr_en      (ent_wr[g]),
            .wr_kind    (fill_kind),
            .lk_hit     (ent_lk_hit[g]),
            .lk_ppn     (ent_lk_ppn[g]),
            .fl_tag_hit (ent_fl_hit[g])
        );
    end

    tlb_sect_rr #(
        .NUM_TAGS (NUM_TAGS)
    ) rr_i (
        .clk (clk),
        .rst (rst),
        .adv (fill_kind == FILL_ALLOC),
        .ptr (rr_ptr)
    );

    tlb_sect_merge #(
        .NUM_TAGS (NUM_TAGS),
        .PPN_W    (PPN_W)
    ) merge_i (
        .hit_vec (ent_lk_hit),
        .ppn_vec (ent_lk_ppn),
        .hit     (lk_hit),
        .ppn     (lk_ppn)
    );

endmodule

// File: rtl/tlb_sect_chk.sv
module tlb_sect_chk
    import tlb_sect_pkg::*;
#(
    parameter int unsigned VPN_W    = DEF_VPN_W,
    parameter int unsigned PPN_W    = DEF_PPN_W,
    parameter int unsigned NUM_TAGS = DEF_TAGS,
    localparam int unsigned IDX_W   = idx_width(NUM_TAGS)
) (
    input logic                clk,
    input logic                rst,
    input logic [VPN_W-1:0]    lk_vpn,
    input logic                lk_hit,
    input logic [PPN_W-1:0]    lk_ppn,
    input logic                fl_en,
    input logic [VPN_W-1:0]    fl_vpn,
    input logic [PPN_W-1:0]    fl_ppn,
    input logic [NUM_TAGS-1:0] ent_lk_hit,
    input logic                any_fl_hit,
    input logic [IDX_W-1:0]    rr_ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TAGS - 1);

    // R1
    reset_miss_chk: assert property (@(posedge clk)
        rst |=> !lk_hit);

    // R2
    hit_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ent_lk_hit));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ppn == '0));

    // R5
    fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fl_en) && (lk_vpn == $past(fl_vpn)))
        |-> (lk_hit && (lk_ppn == $past(fl_ppn))));

    // R7
    rr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fl_en) && !$past(any_fl_hit))
        |-> (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1)));

    // R6
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !($past(fl_en) && !$past(any_fl_hit)))
        |-> $stable(rr_ptr));

endmodule

bind tlb_sect tlb_sect_chk #(
    .VPN_W    (VPN_W),
    .PPN_W    (PPN_W),
    .NUM_TAGS (NUM_TAGS)
) chk_i (.*);

// File: tb/tlb_sect_tb_top.sv
module tlb_sect_tb_top;

    localparam int CLK_P = 10;
    localparam int VW    = 20;
    localparam int PW    = 16;
    localparam int NT    = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [VW-1:0] lk_vpn;
    logic          lk_hit;
    logic [PW-1:0] lk_ppn;
    logic          fl_en;
    logic [VW-1:0] fl_vpn;
    logic [PW-1:0] fl_ppn;

    int compared = 0;
    int mism     = 0;

    // behavioural reference state
    bit            m_tv  [NT];
    logic [VW-2:0] m_tag [NT];
    bit            m_sv  [NT][2];
    logic [PW-1:0] m_ppn [NT][2];
    int            m_ptr;

    always #(CLK_P/2) clk = ~clk;

    tlb_sect #(.VPN_W(VW), .PPN_W(PW), .NUM_TAGS(NT)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .lk_vpn (lk_vpn),
        .lk_hit (lk_hit),
        .lk_ppn (lk_ppn),
        .fl_en  (fl_en),
        .fl_vpn (fl_vpn),
        .fl_ppn (fl_ppn)
    );

    function automatic void model_clear();
        for (int i = 0; i < NT; i++) begin
            m_tv[i] = 0; m_sv[i][0] = 0; m_sv[i][1] = 0;
        end
        m_ptr = 0;
    endfunction

    function automatic void model_look(input logic [VW-1:0] v,
                                       output logic h, output logic [PW-1:0] p);
        h = 1'b0; p = '0;
        for (int i = 0; i < NT; i++)
            if (m_tv[i] && m_tag[i] == v[VW-1:1] && m_sv[i][v[0]]) begin
                h = 1'b1; p = m_ppn[i][v[0]];
            end
    endfunction

    function automatic void model_fill(input logic [VW-1:0] v, input logic [PW-1:0] p);
        int idx = -1;
        for (int i = 0; i < NT; i++)
            if (m_tv[i] && m_tag[i] == v[VW-1:1]) idx = i;
        if (idx < 0) begin
            idx = m_ptr;
            m_ptr = (m_ptr + 1) % NT;
            m_tv[idx] = 1; m_tag[idx] = v[VW-1:1];
            m_sv[idx][0] = 0; m_sv[idx][1] = 0;
        end
        m_sv[idx][v[0]] = 1;
        m_ppn[idx][v[0]] = p;
    endfunction

    task automatic step(input logic fe, input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                        input logic [VW-1:0] lv, input string req);
        logic          eh;
        logic [PW-1:0] ep;
        fl_en = fe; fl_vpn = fv; fl_ppn = fp; lk_vpn = lv;
        @(negedge clk);
        model_look(lv, eh, ep);
        compared++;
        if (lk_hit !== eh || lk_ppn !== ep) begin
            mism++;
            $display("FAIL %s: vpn=%h got hit=%b ppn=%h expected hit=%b ppn=%h",
                     req, lv, lk_hit, lk_ppn, eh, ep);
        end
        @(posedge clk);
        if (fe && !rst) model_fill(fv, fp);
        #1;
    endtask

    task automatic look(input logic [VW-1:0] lv, input string req);
        step(1'b0, '0, '0, lv, req);
    endtask

    task automatic fill(input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                        input logic [VW-1:0] lv, input string req);
        step(1'b1, fv, fp, lv, req);
    endtask

    initial begin
        rst = 1'b1; fl_en = 1'b0; fl_vpn = '0; fl_ppn = '0; lk_vpn = '0;
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset
        look(20'h00000, "R1");
        look(20'h00011, "R1");

        // R5: lookup in the fill's own cycle sees the old contents
        fill(20'h00010, 16'hA000, 20'h00010, "R5 same-cycle");
        look(20'h00010, "R2 R5 even hit");
        // R3: tag matches but odd half invalid
        look(20'h00011, "R3 R4 odd invalid");
        // R6: merge into existing tag
        fill(20'h00011, 16'hB000, 20'h00011, "R5");
        look(20'h00010, "R6 partner kept");
        look(20'h00011, "R2 R6 odd hit");
        // R8: overwrite
        fill(20'h00010, 16'hC000, 20'h00010, "R8 same-cycle old");
        look(20'h00010, "R8 replaced");
        look(20'h00012, "R2 R4 other tag");

        // R7: seven more allocations fill entries 1..7
        for (int t = 1; t < NT; t++)
            fill(VW'(20'h00100 + 2*t), PW'(16'h1000 + t), 20'h00010, "R7 fill");
        look(20'h00010, "R7 before wrap");
        // wrap: odd fill claims entry 0, lookup of victim in same cycle
        fill(20'h00301, 16'hD001, 20'h00011, "R5 R7 victim same-cycle");
        look(20'h00010, "R7 victim even gone");
        look(20'h00011, "R7 victim odd gone");
        look(20'h00300, "R7 partner invalid");
        look(20'h00301, "R7 new odd");
        look(20'h00102, "R7 entry1 kept");
        fill(20'h00500, 16'hE000, 20'h00102, "R7 evict entry1");
        look(20'h00102, "R7 entry1 gone");

        // R1: reset again mid-run
        rst = 1'b1;
        @(posedge clk);
        model_clear();
        #1 rst = 1'b0;
        look(20'h00301, "R1 after rerun reset");
        look(20'h00104, "R1 after rerun reset");

        // R9: full capacity, both halves
        for (int t = 0; t < NT; t++) begin
            fill(VW'(20'h00800 + 2*t), PW'(16'h2000 + 2*t), VW'(20'h00800 + 2*t), "R9 fill");
            fill(VW'(20'h00801 + 2*t), PW'(16'h2001 + 2*t), VW'(20'h00800 + 2*t), "R9 fill");
        end
        for (int v = 0; v < 2*NT; v++)
            look(VW'(20'h00800 + v), "R9 all resident");
        look(VW'(20'h00800 + 2*NT), "R9 R4 beyond");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mism++;
        $display("FAIL watchdog: got running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

endmodule